// File: doc/BRIEF.md
# Rate-1/3 Turbo Encoder with Quadratic Permutation Interleaving

This block turns one code block of K information bits into a rate-1/3 parallel-concatenated convolutional code. Two identical 8-state recursive systematic convolutional encoders run side by side. The first sees the bits in natural order. The second sees them in the order given by a quadratic permutation polynomial. For every index the block emits a triple made of the systematic bit, the first parity bit and the second parity bit. Four tail triples then return both encoders to the all-zero state.

A block starts with a one-cycle request that carries the block length. The length picks a coefficient pair from a small internal table; a length with no entry is rejected with an error pulse. The K information bits are written into an internal bit buffer through a valid/ready handshake. Encoding starts only once the whole block is stored, because the interleaved branch needs random reads. The coded stream leaves through a second valid/ready handshake. While the consumer holds off, everything in the encoder freezes.

The interleaved read address is produced step by step from two running sums, each kept below K with a single conditional subtraction, so no multiplier is needed.

Top module: `turbo_qpp_encoder`

## Requirements
- R1: While reset is held and in the first cycle after it is released, out_valid, in_ready and size_err are low.
- R2: The supported lengths and their (f1, f2) pairs are 40 (3,10), 200 (13,50), 400 (151,40), 640 (39,80), 1024 (31,64) and 6144 (263,480). If blk_start is high in the idle state with a supported blk_len, in_ready is high in the next cycle and size_err stays low.
- R3: If blk_start is high in the idle state with any other blk_len, size_err is high for exactly one cycle in the next cycle. Nothing is loaded: in_ready and out_valid stay low.
- R4: During loading, in_ready stays high until exactly K bits have been accepted (in_valid and in_ready both high), and an idle in_valid cycle is skipped. After the K-th bit, in_ready is low and out_valid is high. in_ready and out_valid are never high together.
- R5: For data triple i (0 <= i < K), out_sys equals the i-th accepted input bit c(i).
- R6: For data triple i, out_par1 is the parity of an encoder with feedback 1+D^2+D^3 and feedforward 1+D+D^3. For state bits s0 (newest), s1 and s2, cleared to zero at the start of each block, a = u^s1^s2, parity = a^s0^s2, and the next state is (a, s0, s1), with u = c(i).
- R7: For data triple i, out_par2 is the parity of a second, identical encoder, also starting from zero, fed with u = c(P(i)), where P(i) = (f1*i + f2*i*i) mod K.
- R8: Four tail triples follow the data with out_tail high. Each encoder is terminated by three steps with input x = s1^s2, giving parities z0..z2; x0..x2/z0..z2 belong to the first encoder and y0..y2/w0..w2 to the second. The triples (out_sys, out_par1, out_par2) are (x0,z0,x1), (z1,x2,z2), (y0,w0,y1), (w1,y2,w2). out_last is high only on the fourth tail triple.
- R9: While out_valid is high and out_ready is low, out_valid and every output bit hold their values in the next cycle.
- R10: blk_start is ignored outside the idle state: a request during loading changes neither the block length nor the coded stream.
- R11: After the handshake of the last tail triple, out_valid and in_ready are low, and the next block is encoded from cleared encoder state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| blk_start | input | 1 | Start request for a new block, taken in idle only |
| blk_len | input | KW (13) | Block length K presented with blk_start |
| size_err | output | 1 | One-cycle pulse for an unsupported length |
| in_valid | input | 1 | Input bit valid |
| in_ready | output | 1 | Encoder is accepting information bits |
| in_bit | input | 1 | Information bit |
| out_valid | output | 1 | Output triple valid |
| out_ready | input | 1 | Consumer accepts the triple |
| out_sys | output | 1 | Systematic bit, or first tail bit of the triple |
| out_par1 | output | 1 | Parity of encoder 1, or second tail bit |
| out_par2 | output | 1 | Parity of encoder 2, or third tail bit |
| out_tail | output | 1 | Triple belongs to the termination part |
| out_last | output | 1 | Final triple of the block |

## Verification
On every cycle the assertions check the handshake rules: outputs frozen under backpressure, loading and output phases mutually exclusive, the error pulse lasting one cycle with nothing loaded, the final-triple flag only inside the tail, and the return to idle after it. The coded values themselves can only be shown by the bench scenarios. These compare every data and tail triple against a reference encoder and a directly multiplied permutation polynomial for each supported length, under input gaps, random backpressure, a stray start request and a block with a single set bit.

// File: rtl/turbo_enc_pkg.sv
// Shared definitions for the turbo encoder.
// Assumes: one block in flight at a time; the phase order is idle, load, data, tail.
package turbo_enc_pkg;

    // Control phase of the block sequencer
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_DATA = 2'd2,
        PH_TAIL = 2'd3
    } enc_phase_t;

    // Number of termination steps per constituent encoder
    localparam int TERM_STEPS = 3;
    // Number of tail triples on the output
    localparam int TAIL_BEATS = 4;
    localparam int TAIL_CW    = $clog2(TAIL_BEATS);

endpackage

// File: rtl/qpp_coef_lut.sv
// Coefficient lookup for the quadratic permutation interleaver.
// Maps a block length to its (f1, f2) pair and flags lengths without an entry.
// Assumes: lengths above MAX_K are treated as unsupported.
module qpp_coef_lut #(
    parameter int MAX_K = 6144,
    localparam int KW   = $clog2(MAX_K + 1)
) (
    input  logic [KW-1:0] k_in,
    output logic          hit,
    output logic [KW-1:0] f1,
    output logic [KW-1:0] f2
);

    // Table decode of the supported lengths
    always_comb begin
        hit = 1'b1;
        f1  = '0;
        f2  = '0;
        case (int'(k_in))
            40:      begin f1 = KW'(3);   f2 = KW'(10);  end
            200:     begin f1 = KW'(13);  f2 = KW'(50);  end
            400:     begin f1 = KW'(151); f2 = KW'(40);  end
            640:     begin f1 = KW'(39);  f2 = KW'(80);  end
            1024:    begin f1 = KW'(31);  f2 = KW'(64);  end
            6144:    begin f1 = KW'(263); f2 = KW'(480); end
            default: hit = 1'b0;
        endcase
        if (int'(k_in) > MAX_K) begin
            hit = 1'b0;
        end
    end

endmodule

// File: rtl/qpp_addr_gen.sv
// Multiplier-free generator of the interleaved index P(i) = (f1*i + f2*i^2) mod K.
// Keeps P and its first difference g as running sums; each advance adds and
// performs one conditional subtraction of K.
// Assumes: f1, f2 < K, and init is pulsed once before the first advance.
module qpp_addr_gen #(
    parameter int MAX_K = 6144,
    localparam int KW   = $clog2(MAX_K + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic          adv,
    input  logic [KW-1:0] k_len,
    input  logic [KW-1:0] f1,
    input  logic [KW-1:0] f2,
    output logic [KW-1:0] pi
);

    logic [KW-1:0] pi_q;
    logic [KW-1:0] diff_q;
    logic [KW-1:0] step_q;

    // Modular sum of two residues below m
    function automatic logic [KW-1:0] add_mod(input logic [KW-1:0] a,
                                              input logic [KW-1:0] b,
                                              input logic [KW-1:0] m);
        logic [KW:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= {1'b0, m}) begin
            s = s - {1'b0, m};
        end
        return s[KW-1:0];
    endfunction

    // Running sums: start values on init, one recursion step per advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pi_q   <= '0;
            diff_q <= '0;
            step_q <= '0;
        end else if (init) begin
            pi_q   <= '0;
            diff_q <= add_mod(f1, f2, k_len);
            step_q <= add_mod(f2, f2, k_len);
        end else if (adv) begin
            pi_q   <= add_mod(pi_q, diff_q, k_len);
            diff_q <= add_mod(diff_q, step_q, k_len);
        end
    end

    assign pi = pi_q;

endmodule

// File: rtl/turbo_bit_buffer.sv
// Block bit store, packed into words to keep the array shallow.
// One write port and two asynchronous single-bit read ports.
// Assumes: WORD_W is a power of two; addresses stay below MAX_K.
module turbo_bit_buffer #(
    parameter int MAX_K  = 6144,
    parameter int WORD_W = 32,
    localparam int AW    = $clog2(MAX_K),
    localparam int OFS   = $clog2(WORD_W),
    localparam int DEPTH = (MAX_K + WORD_W - 1) / WORD_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wbit,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic          rbit_a,
    output logic          rbit_b
);

    logic [WORD_W-1:0] mem [DEPTH];

    // Single-bit write into the addressed word
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr[AW-1:OFS]][waddr[OFS-1:0]] <= wbit;
        end
    end

    assign rbit_a = mem[raddr_a[AW-1:OFS]][raddr_a[OFS-1:0]];
    assign rbit_b = mem[raddr_b[AW-1:OFS]][raddr_b[OFS-1:0]];

endmodule

// File: rtl/rsc_encoder.sv
// 8-state recursive systematic convolutional encoder, feedback 1+D^2+D^3,
// feedforward 1+D+D^3. Gives the parity for the present input and, from the
// frozen final state, the three termination inputs and parities.
// Assumes: adv is low during the tail so the final state is held.
module rsc_encoder (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       adv,
    input  logic       u_in,
    output logic       par,
    output logic [2:0] term_x,
    output logic [2:0] term_z
);

    import turbo_enc_pkg::*;

    logic [2:0] st_q;   // st_q[0] newest delay element
    logic       fb;

    assign fb  = u_in ^ st_q[1] ^ st_q[2];
    assign par = fb ^ st_q[0] ^ st_q[2];

    // Shift register: cleared per block, one shift per accepted data triple
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            st_q <= '0;
        end else if (adv) begin
            st_q <= {st_q[1], st_q[0], fb};
        end
    end

    // Termination sequence derived by stepping a copy of the final state
    always_comb begin
        logic [2:0] s;
        s      = st_q;
        term_x = '0;
        term_z = '0;
        for (int j = 0; j < TERM_STEPS; j++) begin
            term_x[j] = s[1] ^ s[2];
            term_z[j] = s[0] ^ s[2];
            s         = {s[1], s[0], 1'b0};
        end
    end

endmodule

// File: rtl/turbo_qpp_encoder.sv
// Rate-1/3 turbo encoder: loads a block, then streams data triples and four
// tail triples. Output state freezes while the consumer holds off.
// Assumes: blk_start is taken only in idle; one block in flight.
module turbo_qpp_encoder #(
    parameter int MAX_K  = 6144,
    parameter int WORD_W = 32,
    localparam int KW    = $clog2(MAX_K + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blk_start,
    input  logic [KW-1:0] blk_len,
    output logic          size_err,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_bit,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          out_sys,
    output logic          out_par1,
    output logic          out_par2,
    output logic          out_tail,
    output logic          out_last
);

    import turbo_enc_pkg::*;

    localparam int AW = $clog2(MAX_K);

    enc_phase_t         phase_q;
    logic [KW-1:0]      klen_q, f1_q, f2_q, idx_q;
    logic [TAIL_CW-1:0] tcnt_q;
    logic               err_q;

    logic               lut_hit;
    logic [KW-1:0]      lut_f1, lut_f2;
    logic [KW-1:0]      pi;
    logic               bit_nat, bit_int;
    logic               par1, par2;
    logic [2:0]         t1x, t1z, t2x, t2z;

    logic in_fire, out_fire, at_last_idx, start_enc, data_fire, tail_done;

    assign in_fire     = (phase_q == PH_LOAD) && in_valid;
    assign out_fire    = out_valid && out_ready;
    assign at_last_idx = (idx_q == klen_q - 1'b1);
    assign start_enc   = in_fire && at_last_idx;
    assign data_fire   = (phase_q == PH_DATA) && out_fire;
    assign tail_done   = (phase_q == PH_TAIL) && out_fire && (tcnt_q == TAIL_CW'(TAIL_BEATS - 1));

    qpp_coef_lut #(.MAX_K(MAX_K)) u_lut (
        .k_in (blk_len),
        .hit  (lut_hit),
        .f1   (lut_f1),
        .f2   (lut_f2)
    );

    turbo_bit_buffer #(.MAX_K(MAX_K), .WORD_W(WORD_W)) u_buf (
        .clk     (clk),
        .we      (in_fire),
        .waddr   (idx_q[AW-1:0]),
        .wbit    (in_bit),
        .raddr_a (idx_q[AW-1:0]),
        .raddr_b (pi[AW-1:0]),
        .rbit_a  (bit_nat),
        .rbit_b  (bit_int)
    );

    qpp_addr_gen #(.MAX_K(MAX_K)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (start_enc),
        .adv   (data_fire),
        .k_len (klen_q),
        .f1    (f1_q),
        .f2    (f2_q),
        .pi    (pi)
    );

    rsc_encoder u_enc_nat (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start_enc),
        .adv    (data_fire),
        .u_in   (bit_nat),
        .par    (par1),
        .term_x (t1x),
        .term_z (t1z)
    );

    rsc_encoder u_enc_int (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start_enc),
        .adv    (data_fire),
        .u_in   (bit_int),
        .par    (par2),
        .term_x (t2x),
        .term_z (t2z)
    );

    // Block sequencer: length capture, load count, data index, tail count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            klen_q  <= '0;
            f1_q    <= '0;
            f2_q    <= '0;
            idx_q   <= '0;
            tcnt_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (blk_start) begin
                        if (lut_hit) begin
                            klen_q  <= blk_len;
                            f1_q    <= lut_f1;
                            f2_q    <= lut_f2;
                            idx_q   <= '0;
                            phase_q <= PH_LOAD;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                PH_LOAD: begin
                    if (in_fire) begin
                        if (at_last_idx) begin
                            idx_q   <= '0;
                            phase_q <= PH_DATA;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                PH_DATA: begin
                    if (data_fire) begin
                        if (at_last_idx) begin
                            tcnt_q  <= '0;
                            phase_q <= PH_TAIL;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                PH_TAIL: begin
                    if (tail_done) begin
                        phase_q <= PH_IDLE;
                    end else if (out_fire) begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Output selection: data triple or one of the four tail triples
    always_comb begin
        out_sys  = 1'b0;
        out_par1 = 1'b0;
        out_par2 = 1'b0;
        if (phase_q == PH_DATA) begin
            out_sys  = bit_nat;
            out_par1 = par1;
            out_par2 = par2;
        end else if (phase_q == PH_TAIL) begin
            case (tcnt_q)
                2'd0:    begin out_sys = t1x[0]; out_par1 = t1z[0]; out_par2 = t1x[1]; end
                2'd1:    begin out_sys = t1z[1]; out_par1 = t1x[2]; out_par2 = t1z[2]; end
                2'd2:    begin out_sys = t2x[0]; out_par1 = t2z[0]; out_par2 = t2x[1]; end
                default: begin out_sys = t2z[1]; out_par1 = t2x[2]; out_par2 = t2z[2]; end
            endcase
        end
    end

    assign in_ready  = (phase_q == PH_LOAD);
    assign out_valid = (phase_q == PH_DATA) || (phase_q == PH_TAIL);
    assign out_tail  = (phase_q == PH_TAIL);
    assign out_last  = (phase_q == PH_TAIL) && (tcnt_q == TAIL_CW'(TAIL_BEATS - 1));
    assign size_err  = err_q;

endmodule

// File: rtl/turbo_qpp_encoder_chk.sv
// Handshake and sequencing checks for the turbo encoder, bound to its ports.
module turbo_qpp_encoder_chk (
    input logic clk,
    input logic rst_n,
    input logic size_err,
    input logic in_ready,
    input logic out_valid,
    input logic out_ready,
    input logic out_sys,
    input logic out_par1,
    input logic out_par2,
    input logic out_tail,
    input logic out_last
);

    // R9: a stalled triple is held unchanged
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sys) && $stable(out_par1)
                                       && $stable(out_par2) && $stable(out_tail) && $stable(out_last)));

    // R4: loading and streaming never overlap
    a_r4_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R3: the error indication lasts a single cycle
    a_r3_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        size_err |=> !size_err);

    // R3: a rejected length starts neither loading nor streaming
    a_r3_err_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        size_err |-> (!in_ready && !out_valid));

    // R8: the final flag only appears on a valid tail triple
    a_r8_last_in_tail: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_valid && out_tail));

    // R8: a consumed non-final tail triple is followed by another tail triple
    a_r8_tail_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (out_tail && out_ready && !out_last) |=> out_tail);

    // R11: the block ends in idle after the final handshake
    a_r11_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (!out_valid && !in_ready));

endmodule

bind turbo_qpp_encoder turbo_qpp_encoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .size_err  (size_err),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sys   (out_sys),
    .out_par1  (out_par1),
    .out_par2  (out_par2),
    .out_tail  (out_tail),
    .out_last  (out_last)
);

// File: tb/sim_turbo_qpp_encoder.sv
module sim_turbo_qpp_encoder;

    localparam int MAXK   = 6144;
    localparam int KW     = $clog2(MAXK + 1);
    localparam int WD_MAX = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          blk_start = 1'b0;
    logic [KW-1:0] blk_len = '0;
    logic          size_err;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          in_bit = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic          out_sys, out_par1, out_par2, out_tail, out_last;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;

    bit [MAXK-1:0] data;
    bit [MAXK+3:0] es, ep1, ep2, etl, elst;

    always #10 clk = ~clk;

    turbo_qpp_encoder #(.MAX_K(MAXK)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_start (blk_start),
        .blk_len   (blk_len),
        .size_err  (size_err),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_bit    (in_bit),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_sys   (out_sys),
        .out_par1  (out_par1),
        .out_par2  (out_par2),
        .out_tail  (out_tail),
        .out_last  (out_last)
    );

    // Watchdog: an expired run is a failure and still prints the summary
    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_MAX) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: cycles %0d expected below %0d", cyc, WD_MAX);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Coefficient pairs from R2
    task automatic get_coef(input int k, output int f1, output int f2);
        case (k)
            40:      begin f1 = 3;   f2 = 10;  end
            200:     begin f1 = 13;  f2 = 50;  end
            400:     begin f1 = 151; f2 = 40;  end
            640:     begin f1 = 39;  f2 = 80;  end
            1024:    begin f1 = 31;  f2 = 64;  end
            default: begin f1 = 263; f2 = 480; end
        endcase
    endtask

    function automatic int perm(input int i, input int k, input int f1, input int f2);
        longint li;
        li = longint'(i);
        return int'((longint'(f1) * li + longint'(f2) * li * li) % longint'(k));
    endfunction

    // Reference encoding per R5, R6, R7 and the tail layout of R8
    task automatic build_ref(input int k);
        int f1, f2;
        bit a0, a1, a2, b0, b1, b2, fa, fb;
        bit [2:0] x, z, y, w;
        get_coef(k, f1, f2);
        {a0, a1, a2, b0, b1, b2} = '0;
        es = '0; ep1 = '0; ep2 = '0; etl = '0; elst = '0;
        for (int i = 0; i < k; i++) begin
            fa = data[i] ^ a1 ^ a2;
            fb = data[perm(i, k, f1, f2)] ^ b1 ^ b2;
            es[i]  = data[i];
            ep1[i] = fa ^ a0 ^ a2;
            ep2[i] = fb ^ b0 ^ b2;
            a2 = a1; a1 = a0; a0 = fa;
            b2 = b1; b1 = b0; b0 = fb;
        end
        for (int j = 0; j < 3; j++) begin
            x[j] = a1 ^ a2;
            z[j] = 1'b0 ^ a0 ^ a2;
            a2 = a1; a1 = a0; a0 = 1'b0;
            y[j] = b1 ^ b2;
            w[j] = 1'b0 ^ b0 ^ b2;
            b2 = b1; b1 = b0; b0 = 1'b0;
        end
        {es[k],   ep1[k],   ep2[k]}   = {x[0], z[0], x[1]};
        {es[k+1], ep1[k+1], ep2[k+1]} = {z[1], x[2], z[2]};
        {es[k+2], ep1[k+2], ep2[k+2]} = {y[0], w[0], y[1]};
        {es[k+3], ep1[k+3], ep2[k+3]} = {w[1], y[2], w[2]};
        for (int t = 0; t < 4; t++) etl[k+t] = 1'b1;
        elst[k+3] = 1'b1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!out_valid && !in_ready && !size_err, "R1 in reset",
              {out_valid, in_ready, size_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !in_ready && !size_err, "R1 after release",
              {out_valid, in_ready, size_err}, 0);
    endtask

    task automatic bad_length(input int k);
        @(negedge clk);
        blk_start = 1'b1;
        blk_len   = KW'(k);
        @(negedge clk);
        blk_start = 1'b0;
        check(size_err == 1'b1, "R3 error raised", size_err, 1);
        check(!in_ready && !out_valid, "R3 nothing loaded", {in_ready, out_valid}, 0);
        @(negedge clk);
        check(size_err == 1'b0, "R3 single-cycle error", size_err, 0);
        check(!in_ready && !out_valid, "R3 still idle", {in_ready, out_valid}, 0);
    endtask

    // pat: 0 random, 1 all zero, 2 single one at k/3
    task automatic run_block(input int k, input int pat, input bit gaps,
                             input bit bp, input bit poke);
        int n, guard, bad_ld;
        bit hold;
        logic [4:0] prev, act, exp;
        for (int i = 0; i < k; i++) begin
            data[i] = (pat == 0) ? 1'($urandom) : ((pat == 2) && (i == k / 3));
        end
        build_ref(k);
        @(negedge clk);
        blk_start = 1'b1;
        blk_len   = KW'(k);
        @(negedge clk);
        blk_start = 1'b0;
        check(in_ready == 1'b1, "R2 loading begins", in_ready, 1);
        check(size_err == 1'b0, "R2 no error for a supported length", size_err, 0);
        bad_ld = 0;
        for (int i = 0; i < k; i++) begin
            if (gaps && (i % 7 == 3)) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            if (!in_ready || out_valid) bad_ld++;
            in_valid = 1'b1;
            in_bit   = data[i];
            if (poke && (i == 5)) begin
                blk_start = 1'b1;
                blk_len   = KW'(40);
            end
            @(negedge clk);
            blk_start = 1'b0;
        end
        in_valid = 1'b0;
        check(bad_ld == 0, "R4 ready throughout loading", bad_ld, 0);
        check(!in_ready && out_valid, "R4 loading ends after K bits", {in_ready, out_valid}, 1);
        n = 0; guard = 0; hold = 1'b0; prev = '0;
        while (n < k + 4 && guard < 40000) begin
            out_ready = bp ? (($urandom % 3) != 0) : 1'b1;
            act = {out_tail, out_last, out_sys, out_par1, out_par2};
            if (hold) begin
                check(out_valid && (act == prev), "R9 stalled triple held", act, prev);
            end
            exp = {etl[n], elst[n], es[n], ep1[n], ep2[n]};
            if (!out_valid) begin
                check(1'b0, "R4 stream gap", 0, 1);
            end else if (out_ready) begin
                if (n < k) check(act == exp, "R5 R6 R7 data triple", act, exp);
                else       check(act == exp, "R8 tail triple", act, exp);
                n++;
            end
            hold = out_valid && !out_ready;
            prev = act;
            @(negedge clk);
            guard++;
        end
        out_ready = 1'b0;
        check(n == k + 4, "R10 triple count", n, k + 4);
        check(!out_valid && !in_ready, "R11 idle after the block", {out_valid, in_ready}, 0);
    endtask

    initial begin
        do_reset();
        bad_length(41);
        run_block(40, 0, 1'b0, 1'b0, 1'b0);
        run_block(40, 1, 1'b0, 1'b0, 1'b0);
        run_block(200, 0, 1'b1, 1'b1, 1'b1);
        run_block(400, 2, 1'b0, 1'b1, 1'b0);
        run_block(640, 0, 1'b1, 1'b0, 1'b0);
        run_block(1024, 0, 1'b0, 1'b1, 1'b0);
        bad_length(6145);
        run_block(6144, 0, 1'b0, 1'b0, 1'b0);
        run_block(40, 2, 1'b0, 1'b0, 1'b0);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule